// File: doc/BRIEF.md
# Tamper Input Watcher with Event Timestamp

This block monitors a tamper or event input and records when it first trips. The input passes through a two-flop synchroniser and a stability filter counted in ticks of a 32.768 kHz enable. The filter needs the input to stay high for a selectable number of consecutive ticks. To save power, the block can look at the input only during short windows that repeat at a low rate. During each window it pulses the pull-up enable, and only the last ticks of the window count towards the filter.

When an event qualifies, a sticky flag sets and the active-low detect output drops. The six live time fields are copied into timestamp registers, and a clock-halt request can be raised. Only the first event after a clear is recorded. The flag stays set until the host clears it. The host clears it either by writing a 0 to it or by reading status with auto-clear enabled. An enable bit gates the whole detector. Another bit forces the detect output inactive while the system runs on its backup supply.

The tick rate is the parameter `TPS`, with a default of 32768. All filter lengths and sampling periods are derived from it. `SETTLE` sets the pull-up settle ticks at the start of each sampling window.

Top module: `tamper_stamp`

## Requirements
- R1: After reset, `ev_flag`=0, `det_n`=1, `halt_req`=0 and all six timestamp outputs are 0.
- R2: In continuous mode, an event needs the synchronised input high on N consecutive ticks. `flt_sel` selects N: 00→1, 01→TPS/256, 10→TPS/64, 11→TPS/32. One low tick restarts the count. With a tick on every clock, a high pulse lasting L clocks qualifies only if L ≥ N.
- R3: Consider the no-filter case with a tick on every clock. `ev_flag` sets on the third rising edge that samples `ev_pin` high. Once set, it stays set until a clear. While set and not gated by R7, `det_n` is 0.
- R4: A clear happens when `clr_wr`=1 with `clr_val`=0, or when `stat_rd`=1 with `auto_clr`=1. `clr_wr` with `clr_val`=1 has no effect. `stat_rd` with `auto_clr`=0 has no effect. If a qualifying event occurs in the same cycle as a clear, the event wins and the flag stays set.
- R5: When the flag goes from 0 to 1, the timestamp registers capture `now_sec`, `now_min`, `now_hr`, `now_date`, `now_mon` and `now_yr`. `now_hr` includes its 12/24 bit. While the flag stays set, the timestamp does not change.
- R6: With `det_en`=0, no event is detected, the timestamp is left unchanged and `pu_on` is 0.
- R7: With `bat_gate`=1 and `on_backup`=1, `det_n` is 1 whatever the flag holds. The flag itself is kept.
- R8: `halt_req` equals `ev_flag` AND `halt_en`.
- R9: `smp_sel` selects the sampling mode: 00 is continuous. 01, 10 and 11 open a window every TPS/2, TPS and 4·TPS ticks respectively. Each window lasts SETTLE+N ticks with `pu_on`=1. Only its final N ticks feed the filter, so input highs outside those ticks do not produce an event.
- R10: With `pu_off`=1, `pu_on` is always 0. In continuous mode with the detector enabled, `pu_on` is 1 continuously.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | 32.768 kHz enable, one clock wide |
| ev_pin | input | 1 | Raw event input, high means event |
| det_en | input | 1 | Detector enable |
| smp_sel | input | 2 | Sampling mode select |
| flt_sel | input | 2 | Stability filter select |
| pu_off | input | 1 | Disables the pull-up enable |
| bat_gate | input | 1 | Forces detect output inactive on backup supply |
| on_backup | input | 1 | System running on backup supply |
| halt_en | input | 1 | Allows a clock-halt request on event |
| auto_clr | input | 1 | Status read clears the flag |
| stat_rd | input | 1 | Status read strobe |
| clr_wr | input | 1 | Status write strobe for the flag |
| clr_val | input | 1 | Value written to the flag |
| now_sec | input | TW | Live seconds |
| now_min | input | TW | Live minutes |
| now_hr | input | TW | Live hours with 12/24 bit |
| now_date | input | TW | Live date |
| now_mon | input | TW | Live month |
| now_yr | input | TW | Live year |
| ev_flag | output | 1 | Sticky event flag |
| det_n | output | 1 | Active-low detect output |
| halt_req | output | 1 | Clock halt request |
| pu_on | output | 1 | Pull-up enable |
| ts_sec | output | TW | Captured seconds |
| ts_min | output | TW | Captured minutes |
| ts_hr | output | TW | Captured hours |
| ts_date | output | TW | Captured date |
| ts_mon | output | TW | Captured month |
| ts_yr | output | TW | Captured year |

## Verification
The filter is exercised with random high pulses whose lengths lie on both sides of each filter length, plus pulses of exactly N and N−1 ticks. These separate an off-by-one in the count from a wrong encoding. Held-high inputs are combined with clears in the same cycle to show whether set or clear has priority. Repeat events with changed time fields show whether the timestamp is overwritten. In sampling mode, the distance between successive pull-up pulses and the width of each pulse distinguish the three rates. An input high only between windows must not trip the detector, while a held input must.

// File: rtl/ts_pkg.sv
package ts_pkg;
  // Consecutive high ticks needed for a qualified event
  function automatic int filt_len(logic [1:0] sel, int tps);
    case (sel)
      2'b00:   return 1;
      2'b01:   return tps / 256;
      2'b10:   return tps / 64;
      default: return tps / 32;
    endcase
  endfunction

  // Ticks between sampling windows
  function automatic int smp_period(logic [1:0] sel, int tps);
    case (sel)
      2'b01:   return tps / 2;
      2'b10:   return tps;
      2'b11:   return tps * 4;
      default: return 1;
    endcase
  endfunction
endpackage

// File: rtl/ts_sync.sv
module ts_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain;
  always_ff @(posedge clk) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-2:0], din};
  end
  assign dout = chain[STAGES-1];
endmodule

// File: rtl/ts_pacer.sv
module ts_pacer #(
  parameter int TPS    = 32768,
  parameter int SETTLE = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       en,
  input  logic       pu_off,
  input  logic [1:0] smp_sel,
  input  logic [1:0] flt_sel,
  output logic       eval_o,
  output logic       pu_on_o
);
  localparam int PW = $clog2(4 * TPS) + 1;

  logic [PW-1:0] cnt;
  logic [1:0]    sel_q;
  logic [PW-1:0] per_v, win_end, settle_v;
  logic          window;

  always_comb begin
    per_v    = PW'(ts_pkg::smp_period(smp_sel, TPS));
    settle_v = PW'(SETTLE);
    win_end  = settle_v + PW'(ts_pkg::filt_len(flt_sel, TPS));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt   <= '0;
      sel_q <= 2'b00;
    end else begin
      sel_q <= smp_sel;
      if (smp_sel != sel_q || smp_sel == 2'b00) cnt <= '0;
      else if (tick) cnt <= (cnt >= per_v - PW'(1)) ? '0 : cnt + PW'(1);
    end
  end

  assign window  = (smp_sel == 2'b00) ? 1'b1 : (cnt < win_end);
  assign eval_o  = (smp_sel == 2'b00) ? 1'b1 : (cnt >= settle_v && cnt < win_end);
  assign pu_on_o = en && !pu_off && window;

  // R10
  pu_off_chk: assert property (@(posedge clk) disable iff (!rst_n) pu_off |-> !pu_on_o);
endmodule

// File: rtl/ts_filter.sv
module ts_filter #(
  parameter int TPS = 32768
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       en,
  input  logic       eval,
  input  logic       din,
  input  logic [1:0] flt_sel,
  output logic       hit
);
  localparam int NMAX = TPS / 32;
  localparam int RW   = $clog2(NMAX + 2) + 1;

  logic [RW-1:0] run, run_p1, need;

  always_comb begin
    need   = RW'(ts_pkg::filt_len(flt_sel, TPS));
    run_p1 = run + RW'(1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) run <= '0;
    else if (tick) begin
      if (en && eval && din) run <= (run_p1 > RW'(NMAX)) ? RW'(NMAX) : run_p1;
      else                   run <= '0;
    end
  end

  assign hit = tick && en && eval && din && (run_p1 >= need);
endmodule

// File: rtl/ts_capture.sv
module ts_capture #(
  parameter int TW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hit,
  input  logic          clr,
  input  logic [6*TW-1:0] now_all,
  output logic          flag,
  output logic [6*TW-1:0] stamp
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag  <= 1'b0;
      stamp <= '0;
    end else begin
      if (hit && !flag) stamp <= now_all;
      if (hit)      flag <= 1'b1;
      else if (clr) flag <= 1'b0;
    end
  end

  // R3
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n) flag && !clr |=> flag);
  // R5
  stamp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n) flag |=> $stable(stamp));
endmodule

// File: rtl/tamper_stamp.sv
module tamper_stamp #(
  parameter int TPS    = 32768,
  parameter int SETTLE = 8,
  parameter int TW     = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          ev_pin,
  input  logic          det_en,
  input  logic [1:0]    smp_sel,
  input  logic [1:0]    flt_sel,
  input  logic          pu_off,
  input  logic          bat_gate,
  input  logic          on_backup,
  input  logic          halt_en,
  input  logic          auto_clr,
  input  logic          stat_rd,
  input  logic          clr_wr,
  input  logic          clr_val,
  input  logic [TW-1:0] now_sec,
  input  logic [TW-1:0] now_min,
  input  logic [TW-1:0] now_hr,
  input  logic [TW-1:0] now_date,
  input  logic [TW-1:0] now_mon,
  input  logic [TW-1:0] now_yr,
  output logic          ev_flag,
  output logic          det_n,
  output logic          halt_req,
  output logic          pu_on,
  output logic [TW-1:0] ts_sec,
  output logic [TW-1:0] ts_min,
  output logic [TW-1:0] ts_hr,
  output logic [TW-1:0] ts_date,
  output logic [TW-1:0] ts_mon,
  output logic [TW-1:0] ts_yr
);
  logic sync_lvl, eval_win, ev_hit, clr_req, out_gated;
  logic [6*TW-1:0] now_all, stamp_all;

  ts_sync #(.STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(ev_pin), .dout(sync_lvl)
  );

  ts_pacer #(.TPS(TPS), .SETTLE(SETTLE)) u_pacer (
    .clk(clk), .rst_n(rst_n), .tick(tick), .en(det_en), .pu_off(pu_off),
    .smp_sel(smp_sel), .flt_sel(flt_sel), .eval_o(eval_win), .pu_on_o(pu_on)
  );

  ts_filter #(.TPS(TPS)) u_filt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .en(det_en), .eval(eval_win),
    .din(sync_lvl), .flt_sel(flt_sel), .hit(ev_hit)
  );

  assign now_all = {now_yr, now_mon, now_date, now_hr, now_min, now_sec};
  assign clr_req = (clr_wr && !clr_val) || (stat_rd && auto_clr);

  ts_capture #(.TW(TW)) u_cap (
    .clk(clk), .rst_n(rst_n), .hit(ev_hit), .clr(clr_req),
    .now_all(now_all), .flag(ev_flag), .stamp(stamp_all)
  );

  assign {ts_yr, ts_mon, ts_date, ts_hr, ts_min, ts_sec} = stamp_all;
  assign out_gated = bat_gate && on_backup;
  assign det_n     = !(ev_flag && !out_gated);
  assign halt_req  = ev_flag && halt_en;

  // R6
  no_rise_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ev_flag) |-> $past(det_en));
  // R7
  backup_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bat_gate && on_backup) |-> det_n);
endmodule

// File: tb/sim_tamper_stamp.sv
module sim_tamper_stamp;
  localparam int TPS = 1024;
  localparam int SET = 8;
  localparam int TW  = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0, tick = 1'b1, ev_pin = 1'b0, det_en = 1'b1;
  logic [1:0] smp_sel = 2'b00, flt_sel = 2'b00;
  logic pu_off = 0, bat_gate = 0, on_backup = 0, halt_en = 0, auto_clr = 0;
  logic stat_rd = 0, clr_wr = 0, clr_val = 0;
  logic [TW-1:0] now_sec = 0, now_min = 0, now_hr = 0, now_date = 0, now_mon = 0, now_yr = 0;
  logic ev_flag, det_n, halt_req, pu_on;
  logic [TW-1:0] ts_sec, ts_min, ts_hr, ts_date, ts_mon, ts_yr;

  int tests = 0, fails = 0, cyc = 0;

  always #2.5 clk = ~clk;

  tamper_stamp #(.TPS(TPS), .SETTLE(SET), .TW(TW)) u0 (.*);

  function automatic int need_of(int sel);
    if (sel == 0) return 1;
    if (sel == 1) return TPS >> 8;
    if (sel == 2) return TPS >> 6;
    return TPS >> 5;
  endfunction

  function automatic int period_of(int sel);
    if (sel == 1) return TPS >> 1;
    if (sel == 2) return TPS;
    return TPS << 2;
  endfunction

  function automatic logic [47:0] now_v();
    return {now_yr, now_mon, now_date, now_hr, now_min, now_sec};
  endfunction

  function automatic logic [47:0] ts_v();
    return {ts_yr, ts_mon, ts_date, ts_hr, ts_min, ts_sec};
  endfunction

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(string tag, longint act, longint exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic do_clear();
    clr_wr = 1; clr_val = 0; step(1); clr_wr = 0;
  endtask

  task automatic rand_time();
    now_sec = 8'($urandom % 60); now_min = 8'($urandom % 60);
    now_hr = 8'($urandom); now_date = 8'(1 + $urandom % 31);
    now_mon = 8'(1 + $urandom % 12); now_yr = 8'($urandom % 100);
  endtask

  task automatic wait_rise(output int waited);
    logic prev;
    waited = 0;
    prev = pu_on;
    for (int i = 0; i < 10000; i++) begin
      step(1); waited++;
      if (pu_on && !prev) break;
      prev = pu_on;
    end
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 150000) begin
      fails++;
      $display("FAIL watchdog: actual %0d expected done", cyc);
      $display("  [TB] %0d tests run, %0d failed", tests + 1, fails);
      $finish;
    end
  end

  initial begin
    logic [47:0] saved;
    int w, hi;
    void'($urandom(32'd4711));
    step(3); rst_n = 1; step(1);
    // R1 reset state
    check("R1 flag", ev_flag, 0);
    check("R1 det_n", det_n, 1);
    check("R1 halt", halt_req, 0);
    check("R1 stamp", ts_v(), 0);
    // R10 continuous pull-up
    check("R10 pu continuous", pu_on, 1);

    // R3 latency with no filter
    rand_time(); saved = now_v();
    ev_pin = 1; step(2);
    check("R3 not yet", ev_flag, 0);
    step(1);
    check("R3 set", ev_flag, 1);
    check("R3 det_n low", det_n, 0);
    check("R5 capture", ts_v(), saved);
    ev_pin = 0; step(5);
    check("R3 sticky", ev_flag, 1);

    // R8 halt request
    halt_en = 1; step(1);
    check("R8 halt", halt_req, 1);
    halt_en = 0; step(1);
    check("R8 halt off", halt_req, 0);

    // R7 backup gating
    bat_gate = 1; on_backup = 1; step(1);
    check("R7 gated", det_n, 1);
    check("R7 flag kept", ev_flag, 1);
    on_backup = 0; step(1);
    check("R7 ungated", det_n, 0);
    bat_gate = 0;

    // R5 no overwrite while flag set
    rand_time(); ev_pin = 1; step(6); ev_pin = 0; step(4);
    check("R5 held", ts_v(), saved);

    // R4 write of 1 ignored, read without auto ignored, read with auto clears
    clr_wr = 1; clr_val = 1; step(1); clr_wr = 0; clr_val = 0;
    check("R4 write1 ignored", ev_flag, 1);
    stat_rd = 1; step(1); stat_rd = 0;
    check("R4 read no auto", ev_flag, 1);
    auto_clr = 1; stat_rd = 1; step(1); stat_rd = 0; auto_clr = 0;
    check("R4 read auto clears", ev_flag, 0);
    check("R3 det_n released", det_n, 1);

    // R4 event wins over simultaneous clear
    ev_pin = 1; step(5);
    do_clear();
    check("R4 event wins", ev_flag, 1);
    ev_pin = 0; step(4); do_clear();
    check("R4 clear", ev_flag, 0);

    // R2 filter: directed boundary then random lengths
    for (int s = 0; s < 4; s++) begin
      int n;
      flt_sel = 2'(s); n = need_of(s);
      for (int t = 0; t < 8; t++) begin
        int len;
        if (t == 0) len = n;
        else if (t == 1) len = (n > 1) ? n - 1 : 1;
        else len = 1 + int'($urandom % (2 * n + 1));
        rand_time(); saved = now_v();
        ev_pin = 1; step(len); ev_pin = 0; step(n + 6);
        check($sformatf("R2 sel%0d len%0d", s, len), ev_flag, (len >= n) ? 1 : 0);
        if (len >= n) check("R5 stamp", ts_v(), saved);
        do_clear(); step(2);
      end
    end

    // R2 low tick restarts count
    flt_sel = 2'b10;
    ev_pin = 1; step(10); ev_pin = 0; step(1); ev_pin = 1; step(10); ev_pin = 0; step(20);
    check("R2 restart", ev_flag, 0);

    // R6 detector disabled
    saved = ts_v(); rand_time();
    det_en = 0; flt_sel = 2'b00; ev_pin = 1; step(40);
    check("R6 no flag", ev_flag, 0);
    check("R6 pu off", pu_on, 0);
    check("R6 stamp kept", ts_v(), saved);
    ev_pin = 0; step(3); det_en = 1; step(3);

    // R10 pull-up disable
    pu_off = 1; step(1);
    check("R10 pu_off", pu_on, 0);
    pu_off = 0; step(1);

    // R9 sampling periods and window width
    flt_sel = 2'b01;
    for (int s = 1; s < 4; s++) begin
      smp_sel = 2'(s);
      wait_rise(w);
      wait_rise(w);
      check($sformatf("R9 period sel%0d", s), w, period_of(s));
      hi = 0;
      while (pu_on) begin step(1); hi++; end
      check($sformatf("R9 window sel%0d", s), hi, SET + need_of(1));
    end

    // R9 highs between windows ignored, held high detected
    smp_sel = 2'b01;
    wait_rise(w);
    while (pu_on) step(1);
    step(5); ev_pin = 1; step(period_of(1) - (SET + need_of(1)) - 20); ev_pin = 0;
    step(60);
    check("R9 between windows", ev_flag, 0);
    ev_pin = 1; step(period_of(1) + 40);
    check("R9 held detected", ev_flag, 1);
    ev_pin = 0; step(4); do_clear();
    smp_sel = 2'b00; step(2);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule